// File: doc/BRIEF.md
# Cache Line Writeback Queue

This block parks cache lines that are leaving a first-level data cache until the next cache level can take them. A line leaves for one of two reasons. A replacement evicts it, which is a release. The next level asks for it, which is a probe. Each accepted request occupies one of `NE` entries. Every entry runs its own small state machine, and the entry's outbound message (probe acknowledgement or release, with or without data) is handed to a single outbound channel through a round-robin arbiter.

An evicted line can be marked as waiting for a refill. It then stays parked until a refill wake-up that names its block address arrives. A probe for a block that is already parked for release does not take a new entry. It merges into the parked entry, and that entry then sends the probe acknowledgement before the release. Any request whose block address matches a valid outstanding miss entry is held off. Request data and byte mask reach the entry one cycle after the handshake. An entry does not offer a message until that data has landed.

Entry states: `ST_IDLE` (free), `ST_WAIT` (release parked until refill wake-up), `ST_ACK` (probe acknowledgement pending), `ST_REL` (release pending). The transitions are:
- alloc-release-park: `ST_IDLE`→`ST_WAIT`
- alloc-release-go: `ST_IDLE`→`ST_REL`
- alloc-probe: `ST_IDLE`→`ST_ACK`
- wake: `ST_WAIT`→`ST_REL`
- merge: `ST_WAIT`/`ST_REL`→`ST_ACK`
- ack-then-release: `ST_ACK`→`ST_REL`
- ack-done: `ST_ACK`→`ST_IDLE`
- release-done: `ST_REL`→`ST_IDLE`

Top module: `wb_queue`

## Requirements
- R1: After reset `req_ready` is 1 and `out_valid` is 0.
- R2: A request is not accepted (`req_ready`=0) while any `miss_valid[i]` is 1 with `miss_addr` slice i equal to `req_addr`. With no such match the miss vector has no effect.
- R3: A request for a block held by no entry is accepted only when an entry is free, and it takes the lowest-index free entry. With all `NE` entries busy, `req_ready` is 0 for such a request.
- R4: A release (`req_is_probe`=0) with `req_need_refill`=0 produces one message. Its `out_opcode` is 3 (release with data) when `req_has_data`=1 and 2 (release, no data) otherwise. It carries the request address, and the request data and mask when it has data.
- R5: A release with `req_need_refill`=1 produces no message until a cycle with `wake_valid`=1 and `wake_addr` equal to its address. A wake-up for any other address has no effect.
- R6: A probe (`req_is_probe`=1) for a block held by no entry produces one message. Its opcode is 1 (probe ack with data) when `req_has_data`=1 and 0 (probe ack, no data) otherwise.
- R7: A probe for a block parked in `ST_WAIT`, or in `ST_REL` but not currently offered on the outbound channel, is accepted even with no free entry and merges into that entry. The entry then sends a probe ack first and a release afterwards. The ack has opcode 1 if the probe or the parked release had data, and opcode 0 otherwise. The release that follows has opcode 2.
- R8: A release for a block already held by an entry is not accepted. A probe for a block whose entry is in `ST_ACK`, or whose release is currently being offered, is not accepted either.
- R9: `out_corrupt` is 1 on a message carrying data (opcodes 1 and 3) when any request merged into that entry had `req_corrupt`=1. It is 0 on all other messages.
- R10: Messages from several entries are granted round-robin, starting after the last accepted entry. While `out_ready` is 0 the offered message stays unchanged. An entry becomes free when its final message is accepted.
- R11: Request data and mask are written into the entry one cycle after the handshake edge. The entry's message is offered no earlier than the second edge after the handshake. The data of a merged probe that has data replaces the parked line's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_probe | input | 1 | 1 = probe, 0 = release |
| req_need_refill | input | 1 | Release must wait for a refill wake-up |
| req_has_data | input | 1 | Request carries line data |
| req_corrupt | input | 1 | Line had a data ECC error |
| req_addr | input | AW | Block address |
| req_data | input | DW | Line data |
| req_mask | input | DW/8 | Byte mask |
| miss_valid | input | NM | Valid bits of outstanding miss entries |
| miss_addr | input | NM*AW | Block addresses of miss entries, slice i at [i*AW +: AW] |
| wake_valid | input | 1 | Refill completed |
| wake_addr | input | AW | Block address of the line the refill replaced |
| out_valid | output | 1 | Outbound message offered |
| out_ready | input | 1 | Next level accepts the message |
| out_opcode | output | 2 | 0 ack, 1 ack+data, 2 release, 3 release+data |
| out_addr | output | AW | Block address |
| out_data | output | DW | Line data |
| out_mask | output | DW/8 | Byte mask |
| out_corrupt | output | 1 | Data is corrupt |

## Verification
The bench sweeps every combination of refill need, data presence and corrupt flag, first for plain releases and then for lone probes. These sweeps separate opcode selection from corrupt gating and from the refill hold. The same eight-way sweep is run over probes merging into a parked release. This checks ack-before-release order, the selection of whose data the ack carries, and the release dropping to no-data. A fill of all entries with a partial drain and refill tells round-robin apart from fixed priority. A fill with staggered wake-ups, mismatched wake-ups, a lowest-free-entry refill and miss-vector conflicts shows which requests are blocked and which pass.

// File: rtl/wb_queue_pkg.sv
package wb_queue_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_REL  = 2'd3
    } wbq_state_e;

    localparam logic [1:0] OP_ACK      = 2'd0;
    localparam logic [1:0] OP_ACK_DATA = 2'd1;
    localparam logic [1:0] OP_REL      = 2'd2;
    localparam logic [1:0] OP_REL_DATA = 2'd3;

endpackage

// File: rtl/wb_queue_slot.sv
module wb_queue_slot
    import wb_queue_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64,
    localparam int MW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          merge,
    input  logic          req_is_probe,
    input  logic          req_need_refill,
    input  logic          req_has_data,
    input  logic          req_corrupt,
    input  logic [AW-1:0] req_addr,
    input  logic          wake_valid,
    input  logic [AW-1:0] wake_addr,
    input  logic          data_wr,
    input  logic [DW-1:0] data_in,
    input  logic [MW-1:0] mask_in,
    input  logic          offered,
    input  logic          accept,
    output logic          busy,
    output logic          mergeable,
    output logic          want,
    output logic [AW-1:0] line_addr,
    output logic [1:0]    msg_opcode,
    output logic [DW-1:0] msg_data,
    output logic [MW-1:0] msg_mask,
    output logic          msg_corrupt
);

    wbq_state_e    state_q, state_d;
    logic          rem_ack_q, rem_ack_d;
    logic          rem_rel_q, rem_rel_d;
    logic          ack_data_q, rel_data_q, corrupt_q, pend_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [MW-1:0] mask_q;
    logic          wake_hit;

    assign wake_hit = wake_valid && (wake_addr == addr_q);

    // next state and remaining-to-send flags
    always_comb begin
        state_d   = state_q;
        rem_ack_d = rem_ack_q;
        rem_rel_d = rem_rel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (alloc) begin
                    if (req_is_probe) begin
                        state_d   = ST_ACK;
                        rem_ack_d = 1'b1;
                        rem_rel_d = 1'b0;
                    end else begin
                        state_d   = req_need_refill ? ST_WAIT : ST_REL;
                        rem_ack_d = 1'b0;
                        rem_rel_d = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (merge) begin
                    state_d   = ST_ACK;
                    rem_ack_d = 1'b1;
                end else if (wake_hit) begin
                    state_d = ST_REL;
                end
            end
            ST_ACK: begin
                if (accept) begin
                    rem_ack_d = 1'b0;
                    state_d   = rem_rel_q ? ST_REL : ST_IDLE;
                end
            end
            ST_REL: begin
                if (merge) begin
                    state_d   = ST_ACK;
                    rem_ack_d = 1'b1;
                end else if (accept) begin
                    rem_rel_d = 1'b0;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_ack_q <= 1'b0;
            rem_rel_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rem_ack_q <= rem_ack_d;
            rem_rel_q <= rem_rel_d;
        end
    end

    // metadata in the handshake cycle, line data one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            ack_data_q <= 1'b0;
            rel_data_q <= 1'b0;
            corrupt_q  <= 1'b0;
            pend_q     <= 1'b0;
            data_q     <= '0;
            mask_q     <= '0;
        end else begin
            pend_q <= alloc || merge;
            if (alloc) begin
                addr_q     <= req_addr;
                corrupt_q  <= req_corrupt;
                ack_data_q <= req_is_probe && req_has_data;
                rel_data_q <= !req_is_probe && req_has_data;
            end else if (merge) begin
                corrupt_q  <= corrupt_q || req_corrupt;
                ack_data_q <= req_has_data || rel_data_q;
                rel_data_q <= 1'b0;
            end
            if (data_wr) begin
                data_q <= data_in;
                mask_q <= mask_in;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mergeable   = (state_q == ST_WAIT) || ((state_q == ST_REL) && !offered);
        want        = ((state_q == ST_ACK) || (state_q == ST_REL)) && !pend_q;
        line_addr   = addr_q;
        msg_data    = data_q;
        msg_mask    = mask_q;
        msg_opcode  = OP_ACK;
        msg_corrupt = 1'b0;
        unique case (state_q)
            ST_ACK: begin
                msg_opcode  = ack_data_q ? OP_ACK_DATA : OP_ACK;
                msg_corrupt = ack_data_q && corrupt_q;
            end
            ST_REL: begin
                msg_opcode  = rel_data_q ? OP_REL_DATA : OP_REL;
                msg_corrupt = rel_data_q && corrupt_q;
            end
            default: begin
                msg_opcode  = OP_ACK;
                msg_corrupt = 1'b0;
            end
        endcase
    end

    // R3
    alloc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state_q == ST_IDLE));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !wake_hit && !merge) |=> (state_q == ST_WAIT));

    // R7
    rel_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REL) |-> (rem_rel_q && !rem_ack_q));

    // R11
    data_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc || merge) |=> !want);

endmodule

// File: rtl/wb_queue_rr.sv
module wb_queue_rr #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         ready,
    output logic [N-1:0] gnt,
    output logic         valid
);

    logic [IW-1:0] ptr_q;
    logic          lock_q;
    logic [N-1:0]  lock_gnt_q;
    logic [N-1:0]  pick;
    logic [IW-1:0] gnt_idx;

    always_comb begin
        pick = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (pick == '0 && req[j]) pick[j] = 1'b1;
        end
    end

    assign gnt   = lock_q ? lock_gnt_q : pick;
    assign valid = |gnt;

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) gnt_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            lock_q     <= 1'b0;
            lock_gnt_q <= '0;
        end else if (valid && ready) begin
            ptr_q  <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
            lock_q <= 1'b0;
        end else if (valid) begin
            lock_q     <= 1'b1;
            lock_gnt_q <= gnt;
        end
    end

    // R10
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R10
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

endmodule

// File: rtl/wb_queue.sv
module wb_queue
    import wb_queue_pkg::*;
#(
    parameter int NE = 4,
    parameter int NM = 4,
    parameter int AW = 16,
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_probe,
    input  logic             req_need_refill,
    input  logic             req_has_data,
    input  logic             req_corrupt,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [DW/8-1:0]  req_mask,
    input  logic [NM-1:0]    miss_valid,
    input  logic [NM*AW-1:0] miss_addr,
    input  logic             wake_valid,
    input  logic [AW-1:0]    wake_addr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_opcode,
    output logic [AW-1:0]    out_addr,
    output logic [DW-1:0]    out_data,
    output logic [DW/8-1:0]  out_mask,
    output logic             out_corrupt
);

    localparam int MW = DW / 8;

    logic [NM-1:0] miss_hit;
    logic          miss_block;
    logic [NE-1:0] busy, mergeable, want, ent_hit, merge_ok, free_oh;
    logic [NE-1:0] alloc_v, merge_v, gnt;
    logic          any_hit, fire, gnt_valid;
    logic [AW-1:0] e_addr [NE];
    logic [1:0]    e_op   [NE];
    logic [DW-1:0] e_data [NE];
    logic [MW-1:0] e_mask [NE];
    logic [NE-1:0] e_corr;

    logic          dly_v_q;
    logic [NE-1:0] dly_sel_q;
    logic [DW-1:0] dly_data_q;
    logic [MW-1:0] dly_mask_q;

    generate
        for (genvar m = 0; m < NM; m++) begin : g_miss
            assign miss_hit[m] = miss_valid[m] && (miss_addr[m*AW +: AW] == req_addr);
        end
    endgenerate
    assign miss_block = |miss_hit;

    always_comb begin
        free_oh = '0;
        for (int i = 0; i < NE; i++) begin
            if (free_oh == '0 && !busy[i]) free_oh[i] = 1'b1;
        end
    end

    assign ent_hit   = busy & {NE{1'b1}} & hit_vec(req_addr);
    assign merge_ok  = ent_hit & mergeable;
    assign any_hit   = |ent_hit;
    assign req_ready = !miss_block &&
                       (any_hit ? (req_is_probe && |merge_ok) : |free_oh);
    assign fire      = req_valid && req_ready;
    assign alloc_v   = (fire && !any_hit) ? free_oh : '0;
    assign merge_v   = fire ? merge_ok : '0;

    function automatic logic [NE-1:0] hit_vec(input logic [AW-1:0] a);
        logic [NE-1:0] h;
        for (int i = 0; i < NE; i++) h[i] = (e_addr[i] == a);
        return h;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_v_q    <= 1'b0;
            dly_sel_q  <= '0;
            dly_data_q <= '0;
            dly_mask_q <= '0;
        end else begin
            dly_v_q <= fire && req_has_data;
            if (fire) begin
                dly_sel_q  <= any_hit ? merge_ok : free_oh;
                dly_data_q <= req_data;
                dly_mask_q <= req_mask;
            end
        end
    end

    generate
        for (genvar e = 0; e < NE; e++) begin : g_ent
            wb_queue_slot #(.AW(AW), .DW(DW)) u_slot (
                .clk            (clk),
                .rst_n          (rst_n),
                .alloc          (alloc_v[e]),
                .merge          (merge_v[e]),
                .req_is_probe   (req_is_probe),
                .req_need_refill(req_need_refill),
                .req_has_data   (req_has_data),
                .req_corrupt    (req_corrupt),
                .req_addr       (req_addr),
                .wake_valid     (wake_valid),
                .wake_addr      (wake_addr),
                .data_wr        (dly_v_q && dly_sel_q[e]),
                .data_in        (dly_data_q),
                .mask_in        (dly_mask_q),
                .offered        (gnt[e]),
                .accept         (gnt[e] && out_ready),
                .busy           (busy[e]),
                .mergeable      (mergeable[e]),
                .want           (want[e]),
                .line_addr      (e_addr[e]),
                .msg_opcode     (e_op[e]),
                .msg_data       (e_data[e]),
                .msg_mask       (e_mask[e]),
                .msg_corrupt    (e_corr[e])
            );
        end
    endgenerate

    wb_queue_rr #(.N(NE)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (want),
        .ready(out_ready),
        .gnt  (gnt),
        .valid(gnt_valid)
    );

    always_comb begin
        out_valid   = gnt_valid;
        out_opcode  = '0;
        out_addr    = '0;
        out_data    = '0;
        out_mask    = '0;
        out_corrupt = 1'b0;
        for (int i = 0; i < NE; i++) begin
            out_opcode  = out_opcode  | ({2{gnt[i]}}  & e_op[i]);
            out_addr    = out_addr    | ({AW{gnt[i]}} & e_addr[i]);
            out_data    = out_data    | ({DW{gnt[i]}} & e_data[i]);
            out_mask    = out_mask    | ({MW{gnt[i]}} & e_mask[i]);
            out_corrupt = out_corrupt | (gnt[i] & e_corr[i]);
        end
    end

    // R2
    miss_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ((miss_valid & miss_hit) == '0));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
            && $stable(out_opcode) && $stable(out_data) && $stable(out_corrupt)));

    // R3
    single_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_v | merge_v));

endmodule

// File: tb/wb_queue_tb.sv
module wb_queue_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int NM = 4;
    localparam int AW = 16;
    localparam int DW = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_is_probe = 1'b0;
    logic             req_need_refill = 1'b0;
    logic             req_has_data = 1'b0;
    logic             req_corrupt = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_data = '0;
    logic [DW/8-1:0]  req_mask = '0;
    logic [NM-1:0]    miss_valid = '0;
    logic [NM*AW-1:0] miss_addr = '0;
    logic             wake_valid = 1'b0;
    logic [AW-1:0]    wake_addr = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [1:0]       out_opcode;
    logic [AW-1:0]    out_addr;
    logic [DW-1:0]    out_data;
    logic [DW/8-1:0]  out_mask;
    logic             out_corrupt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wb_queue #(.NE(NE), .NM(NM), .AW(AW), .DW(DW)) u_dut (.*);

    function automatic logic [63:0] mkd(input logic [15:0] a, input bit p);
        return p ? {~a, a, 16'h5A5A, a ^ 16'h0F0F} : {a, a + 16'd1, a ^ 16'hFFFF, 16'hC3C3};
    endfunction

    function automatic logic [7:0] mkm(input logic [15:0] a, input bit p);
        return p ? (a[7:0] ^ 8'hF0) : a[7:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setreq(input bit p, input bit rf, input bit hd, input bit cr, input logic [15:0] a);
        req_is_probe    = p;
        req_need_refill = rf;
        req_has_data    = hd;
        req_corrupt     = cr;
        req_addr        = a;
        req_data        = mkd(a, p);
        req_mask        = mkm(a, p);
    endtask

    task automatic peek(input bit p, input logic [15:0] a, input bit exp_rdy, input string tag);
        setreq(p, 1'b0, 1'b0, 1'b0, a);
        req_valid = 1'b0;
        #1;
        chk(req_ready == exp_rdy, tag, 64'(req_ready), 64'(exp_rdy));
    endtask

    task automatic send(input bit p, input bit rf, input bit hd, input bit cr, input logic [15:0] a, input string tag);
        setreq(p, rf, hd, cr, a);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, tag, 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wake(input logic [15:0] a);
        wake_valid = 1'b1;
        wake_addr  = a;
        tick();
        wake_valid = 1'b0;
    endtask

    task automatic quiet(input string tag);
        #1;
        chk(out_valid == 1'b0, tag, 64'(out_valid), 64'd0);
    endtask

    task automatic expect_msg(input logic [1:0] op, input logic [15:0] a, input logic [63:0] d,
                              input logic [7:0] m, input bit cr, input string tag);
        #1;
        chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
        chk(out_opcode == op, {tag, " opcode"}, 64'(out_opcode), 64'(op));
        chk(out_addr == a, {tag, " addr"}, 64'(out_addr), 64'(a));
        if (op[0]) begin
            chk(out_data == d, {tag, " data"}, out_data, d);
            chk(out_mask == m, {tag, " mask"}, 64'(out_mask), 64'(m));
        end
        chk(out_corrupt == cr, {tag, " corrupt"}, 64'(out_corrupt), 64'(cr));
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        chk(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);

        // R10 round robin and stall hold
        for (int i = 0; i < 4; i++) send(1'b0, 1'b0, 1'b1, 1'b0, 16'h0300 + 16'(i), "R10 fill");
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(out_addr == 16'h0300, "R10 stall hold", 64'(out_addr), 64'h300);
            tick();
        end
        expect_msg(2'd3, 16'h0300, mkd(16'h0300, 0), mkm(16'h0300, 0), 1'b0, "R10 rr0");
        expect_msg(2'd3, 16'h0301, mkd(16'h0301, 0), mkm(16'h0301, 0), 1'b0, "R10 rr1");
        send(1'b0, 1'b0, 1'b1, 1'b0, 16'h0310, "R3 refill0");
        send(1'b0, 1'b0, 1'b1, 1'b0, 16'h0311, "R3 refill1");
        tick();
        expect_msg(2'd3, 16'h0302, mkd(16'h0302, 0), mkm(16'h0302, 0), 1'b0, "R10 rr2");
        expect_msg(2'd3, 16'h0303, mkd(16'h0303, 0), mkm(16'h0303, 0), 1'b0, "R10 rr3");
        expect_msg(2'd3, 16'h0310, mkd(16'h0310, 0), mkm(16'h0310, 0), 1'b0, "R10 rr4");
        expect_msg(2'd3, 16'h0311, mkd(16'h0311, 0), mkm(16'h0311, 0), 1'b0, "R10 rr5");
        quiet("R10 drained");

        // R4 R5 R9 R11 release sweep
        for (int c = 0; c < 8; c++) begin
            bit rf, hd, cr;
            logic [15:0] a;
            rf = c[2]; hd = c[1]; cr = c[0];
            a = 16'h0100 + 16'(c);
            send(1'b0, rf, hd, cr, a, "R4 release accept");
            quiet("R11 not offered before data");
            tick();
            if (rf) begin
                quiet("R5 parked");
                tick();
                quiet("R5 parked later");
                wake(a ^ 16'h0080);
                quiet("R5 foreign wake ignored");
                wake(a);
            end
            expect_msg(hd ? 2'd3 : 2'd2, a, mkd(a, 0), mkm(a, 0), hd && cr, "R4 R9 release");
            quiet("R10 entry freed");
        end

        // R6 R9 lone probe sweep
        for (int c = 0; c < 4; c++) begin
            bit hd, cr;
            logic [15:0] a;
            hd = c[1]; cr = c[0];
            a = 16'h0700 + 16'(c);
            send(1'b1, 1'b0, hd, cr, a, "R6 probe accept");
            tick();
            expect_msg(hd ? 2'd1 : 2'd0, a, mkd(a, 1), mkm(a, 1), hd && cr, "R6 R9 probe");
        end

        // R7 R9 R11 merge sweep
        for (int c = 0; c < 8; c++) begin
            bit rh, ph, pc;
            logic [15:0] a;
            rh = c[2]; ph = c[1]; pc = c[0];
            a = 16'h0400 + 16'(c);
            send(1'b0, 1'b1, rh, 1'b0, a, "R7 parked release");
            send(1'b1, 1'b0, ph, pc, a, "R7 merging probe");
            tick();
            expect_msg((rh || ph) ? 2'd1 : 2'd0, a, mkd(a, ph), mkm(a, ph),
                       (rh || ph) && pc, "R7 R11 ack first");
            expect_msg(2'd2, a, '0, '0, 1'b0, "R7 release after ack");
            quiet("R7 merged entry freed");
        end

        // R3 R5 R7 R8 full queue
        for (int i = 0; i < 4; i++) send(1'b0, 1'b1, 1'b1, 1'b0, 16'h0200 + 16'(i), "R3 fill");
        tick();
        peek(1'b0, 16'h02FF, 1'b0, "R3 full blocks new");
        peek(1'b1, 16'h02FF, 1'b0, "R3 full blocks new probe");
        peek(1'b1, 16'h0201, 1'b1, "R7 merge allowed when full");
        peek(1'b0, 16'h0201, 1'b0, "R8 duplicate release blocked");
        wake(16'h02AA);
        quiet("R5 foreign wake on full queue");
        wake(16'h0202);
        expect_msg(2'd3, 16'h0202, mkd(16'h0202, 0), mkm(16'h0202, 0), 1'b0, "R5 wake one");
        peek(1'b0, 16'h02FF, 1'b1, "R3 slot freed");
        for (int i = 0; i < 4; i++) begin
            if (i != 2) begin
                wake(16'h0200 + 16'(i));
                expect_msg(2'd3, 16'h0200 + 16'(i), mkd(16'h0200 + 16'(i), 0),
                           mkm(16'h0200 + 16'(i), 0), 1'b0, "R5 wake rest");
            end
        end
        quiet("R10 all freed");

        // R8 probe onto offered release, R8 probe onto pending ack
        send(1'b0, 1'b0, 1'b1, 1'b1, 16'h0500, "R8 release");
        tick();
        peek(1'b1, 16'h0500, 1'b0, "R8 offered release blocks probe");
        expect_msg(2'd3, 16'h0500, mkd(16'h0500, 0), mkm(16'h0500, 0), 1'b1, "R9 corrupt release");
        send(1'b1, 1'b0, 1'b0, 1'b0, 16'h0510, "R8 probe");
        peek(1'b1, 16'h0510, 1'b0, "R8 ack pending blocks probe");
        tick();
        expect_msg(2'd0, 16'h0510, '0, '0, 1'b0, "R6 ack no data");

        // R2 miss conflict
        miss_addr[2*AW +: AW] = 16'h0600;
        miss_valid = 4'b0100;
        peek(1'b0, 16'h0600, 1'b0, "R2 release blocked by miss");
        peek(1'b1, 16'h0600, 1'b0, "R2 probe blocked by miss");
        peek(1'b0, 16'h0601, 1'b1, "R2 other address passes");
        miss_valid = 4'b1011;
        peek(1'b0, 16'h0600, 1'b1, "R2 invalid miss ignored");
        miss_valid = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule